// File: doc/BRIEF.md
# Floating-Point Subtract Instruction Decoder

This block decodes one 32-bit instruction word that may hold a floating-point subtract. The word can belong to either of two encoding sets. One is a fixed-width set, selected when `mixedSet` is 0. The other is a mixed-width set, selected when `mixedSet` is 1; its first halfword sits in bits 31:16.

The decoder tells the packed-vector form apart from the scalar form. It reports the element size, the lanes per 64-bit register, the number of consecutive registers, and three 5-bit register numbers. It also raises an undefined flag and an unpredictable flag. These are judged from the word and from four status inputs: half-precision support, the control register's vector-length and stride fields, and whether the word sits inside a conditional-execution block.

The decision logic is combinational. The results are captured in a register bank on each clock edge where `inValid` is high and come out one cycle later with `outValid`. The block does not execute the subtract, raise the trap or test the condition code.

Top module: `fp_sub_decode`

## Requirements
- R1: The vector form matches bits[31:23]=111100100 in the fixed set and 111011110 in the mixed set, each with bit21=1, bits[11:8]=1101 and bit4=0. The scalar form matches bits[27:23]=11100, bits[21:20]=11, bits[11:10]=10, bit6=1 and bit4=0. In the fixed set the scalar form also needs bits[31:28]≠1111; in the mixed set it needs bits[31:28]=1110. Any other word sets `noMatch`, and every other output except `outValid` is then 0. `isVector` is 1 for the vector form.
- R2: In the vector form, size bit20=0 gives `elemSize` 01 (32-bit) with 2 lanes, and bit20=1 gives `elemSize` 00 (16-bit) with 4 lanes. Quad bit6 gives `regCount` 2 when set and 1 when clear.
- R3: A vector word with bit6 set is undefined if bit0 of any of its 4-bit register fields is 1. Those bits are bit12 for the destination, bit16 for the first source and bit0 for the second source.
- R4: A 16-bit element is undefined when `halfOk` is 0, in both the vector and the scalar form.
- R5: The extra bits are bit22 for the destination, bit7 for the first source and bit5 for the second source. The fields are bits[15:12], [19:16] and [3:0] in the same order. Vector and 64-bit scalar register numbers are {extra, field}; all other scalar register numbers are {field, extra}.
- R6: The scalar form always reports 1 lane and `regCount` 1. Its size bits[9:8] map 01→`elemSize` 00 (16-bit), 10→01 (32-bit), 11→10 (64-bit), and 00→11, which is undefined.
- R7: The scalar form is undefined when `vecLen` is not 000 or `vecStride` is not 00.
- R8: A 16-bit scalar is unpredictable when bits[31:28]≠1110 in the fixed set, or when `inCondBlock` is 1 in the mixed set. A 16-bit vector in the mixed set is unpredictable when `inCondBlock` is 1.
- R9: `undef` and `unpred` are never both 1; undefined wins.
- R10: Outputs update one cycle after a clock edge with `inValid` high, and `outValid` is high for exactly that cycle. With `inValid` low, the decoded outputs hold their values. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Capture strobe for the word and status |
| instr | input | 32 | Instruction word |
| mixedSet | input | 1 | 1 selects the mixed-width encoding set |
| halfOk | input | 1 | Half precision supported |
| vecLen | input | 3 | Control register vector-length field |
| vecStride | input | 2 | Control register stride field |
| inCondBlock | input | 1 | Word lies inside a conditional-execution block |
| outValid | output | 1 | Decoded result present |
| noMatch | output | 1 | Word is not a subtract encoding |
| isVector | output | 1 | Packed-vector form |
| elemSize | output | 2 | 00 16-bit, 01 32-bit, 10 64-bit, 11 reserved |
| laneCount | output | 3 | Lanes per 64-bit register |
| regCount | output | 2 | Consecutive registers used |
| dstReg | output | 5 | Destination register number |
| srcNReg | output | 5 | First source register number |
| srcMReg | output | 5 | Second source register number |
| undef | output | 1 | Undefined |
| unpred | output | 1 | Unpredictable |

## Verification
Some properties are checked by assertions on every cycle. These are:
- undefined and unpredictable are never raised together;
- a non-matching word never reports a form, size or flag;
- a legal quad vector always has even register numbers;
- scalar results use one lane;
- 16-bit vectors use four lanes;
- the valid strobe follows its input one cycle later.

Only the bench's scenarios can show the exact field positions, the two register-number orderings, the size codes and the legality conditions. The same goes for holding the outputs while idle. The bench checks each of these against hand-worked expected values, using words it encodes itself.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  localparam int FIELD_W = 4;
  localparam int REG_W   = FIELD_W + 1;

  typedef enum logic [1:0] {
    ES_HALF   = 2'b00,
    ES_SINGLE = 2'b01,
    ES_DOUBLE = 2'b10,
    ES_RSV    = 2'b11
  } elemSize_e;

  typedef struct packed {
    logic match;
    logic vecForm;
    logic undef;
    logic unpred;
  } ctrlStrobe_t;
endpackage

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
  import fsd_pkg::*;
(
  input  logic [31:0]   instr,
  input  logic          mixedSet,
  input  logic          halfOk,
  input  logic [2:0]    vecLen,
  input  logic [1:0]    vecStride,
  input  logic          inCondBlock,
  output ctrlStrobe_t   strobe
);
  localparam logic [8:0] VEC_TOP_FIXED = 9'b111100100;
  localparam logic [8:0] VEC_TOP_MIXED = 9'b111011110;
  localparam logic [3:0] COND_ALWAYS   = 4'b1110;
  localparam logic [3:0] COND_NONE     = 4'b1111;

  logic vecTail, vecHit, scaTail, scaHit;
  logic quadBit, vecHalf;
  logic [1:0] scaSize;
  logic [3:0] condField;
  logic vecUndef, vecUnpred, scaUndef, scaUnpred;
  logic rawUndef, rawUnpred;

  assign condField = instr[31:28];
  assign quadBit   = instr[6];
  assign vecHalf   = instr[20];
  assign scaSize   = instr[9:8];

  assign vecTail = instr[21] && (instr[11:8] == 4'b1101) && !instr[4];
  assign vecHit  = vecTail &&
                   (instr[31:23] == (mixedSet ? VEC_TOP_MIXED : VEC_TOP_FIXED));

  assign scaTail = (instr[27:23] == 5'b11100) && (instr[21:20] == 2'b11) &&
                   (instr[11:10] == 2'b10) && instr[6] && !instr[4];
  assign scaHit  = scaTail &&
                   (mixedSet ? (condField == COND_ALWAYS) : (condField != COND_NONE));

  // vector legality
  assign vecUndef  = (quadBit && (instr[12] || instr[16] || instr[0])) ||
                     (vecHalf && !halfOk);
  assign vecUnpred = vecHalf && mixedSet && inCondBlock;

  // scalar legality
  assign scaUndef  = (scaSize == 2'b00) || ((scaSize == 2'b01) && !halfOk) ||
                     (vecLen != 3'b000) || (vecStride != 2'b00);
  assign scaUnpred = (scaSize == 2'b01) &&
                     (mixedSet ? inCondBlock : (condField != COND_ALWAYS));

  always_comb begin
    if (vecHit) begin
      rawUndef  = vecUndef;
      rawUnpred = vecUnpred;
    end else if (scaHit) begin
      rawUndef  = scaUndef;
      rawUnpred = scaUnpred;
    end else begin
      rawUndef  = 1'b0;
      rawUnpred = 1'b0;
    end
  end

  always_comb begin
    strobe.match   = vecHit || scaHit;
    strobe.vecForm = vecHit;
    strobe.undef   = rawUndef;
    strobe.unpred  = rawUnpred && !rawUndef;
  end
endmodule

// File: rtl/fsd_datapath.sv
module fsd_datapath
  import fsd_pkg::*;
#(
  parameter int REG_BITS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capture,
  input  logic [31:0]       instr,
  input  ctrlStrobe_t       strobe,
  output logic              noMatch,
  output logic              isVector,
  output logic [1:0]        elemSize,
  output logic [2:0]        laneCount,
  output logic [1:0]        regCount,
  output logic [REG_W-1:0]  dstReg,
  output logic [REG_W-1:0]  srcNReg,
  output logic [REG_W-1:0]  srcMReg,
  output logic              undef,
  output logic              unpred
);
  localparam logic [2:0] LANES_HALF   = 3'(REG_BITS / 16);
  localparam logic [2:0] LANES_SINGLE = 3'(REG_BITS / 32);

  logic [FIELD_W-1:0] fD, fN, fM;
  logic xD, xN, xM;
  logic highFirst;
  elemSize_e esNext;
  logic [2:0] lanesNext;
  logic [1:0] regsNext;
  logic [REG_W-1:0] dNext, nNext, mNext;

  assign fD = instr[15:12];
  assign fN = instr[19:16];
  assign fM = instr[3:0];
  assign xD = instr[22];
  assign xN = instr[7];
  assign xM = instr[5];

  assign highFirst = strobe.vecForm || (instr[9:8] == 2'b11);

  always_comb begin
    esNext    = ES_HALF;
    lanesNext = '0;
    regsNext  = '0;
    dNext     = '0;
    nNext     = '0;
    mNext     = '0;
    if (strobe.match) begin
      if (strobe.vecForm) begin
        esNext    = instr[20] ? ES_HALF : ES_SINGLE;
        lanesNext = instr[20] ? LANES_HALF : LANES_SINGLE;
        regsNext  = instr[6] ? 2'd2 : 2'd1;
      end else begin
        esNext    = elemSize_e'(instr[9:8] - 2'b01);
        lanesNext = 3'd1;
        regsNext  = 2'd1;
      end
      dNext = highFirst ? {xD, fD} : {fD, xD};
      nNext = highFirst ? {xN, fN} : {fN, xN};
      mNext = highFirst ? {xM, fM} : {fM, xM};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      noMatch   <= 1'b0;
      isVector  <= 1'b0;
      elemSize  <= '0;
      laneCount <= '0;
      regCount  <= '0;
      dstReg    <= '0;
      srcNReg   <= '0;
      srcMReg   <= '0;
      undef     <= 1'b0;
      unpred    <= 1'b0;
    end else if (capture) begin
      noMatch   <= !strobe.match;
      isVector  <= strobe.vecForm;
      elemSize  <= esNext;
      laneCount <= lanesNext;
      regCount  <= regsNext;
      dstReg    <= dNext;
      srcNReg   <= nNext;
      srcMReg   <= mNext;
      undef     <= strobe.undef;
      unpred    <= strobe.unpred;
    end
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(undef && unpred));

  p_nomatch_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    noMatch |-> (!isVector && !undef && !unpred && laneCount == 3'd0));

  p_quad_even_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isVector && regCount == 2'd2 && !undef) |->
      (!dstReg[0] && !srcNReg[0] && !srcMReg[0]));

  p_scalar_lane_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!isVector && !noMatch && regCount != 2'd0) |-> (laneCount == 3'd1));

  p_half_lanes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isVector && elemSize == 2'b00) |-> (laneCount == LANES_HALF));
endmodule

// File: rtl/fp_sub_decode.sv
module fp_sub_decode
  import fsd_pkg::*;
#(
  parameter int REG_BITS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instr,
  input  logic        mixedSet,
  input  logic        halfOk,
  input  logic [2:0]  vecLen,
  input  logic [1:0]  vecStride,
  input  logic        inCondBlock,
  output logic        outValid,
  output logic        noMatch,
  output logic        isVector,
  output logic [1:0]  elemSize,
  output logic [2:0]  laneCount,
  output logic [1:0]  regCount,
  output logic [4:0]  dstReg,
  output logic [4:0]  srcNReg,
  output logic [4:0]  srcMReg,
  output logic        undef,
  output logic        unpred
);
  ctrlStrobe_t strobe;

  fsd_ctrl i_ctrl (
    .instr       (instr),
    .mixedSet    (mixedSet),
    .halfOk      (halfOk),
    .vecLen      (vecLen),
    .vecStride   (vecStride),
    .inCondBlock (inCondBlock),
    .strobe      (strobe)
  );

  fsd_datapath #(.REG_BITS(REG_BITS)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .capture   (inValid),
    .instr     (instr),
    .strobe    (strobe),
    .noMatch   (noMatch),
    .isVector  (isVector),
    .elemSize  (elemSize),
    .laneCount (laneCount),
    .regCount  (regCount),
    .dstReg    (dstReg),
    .srcNReg   (srcNReg),
    .srcMReg   (srcMReg),
    .undef     (undef),
    .unpred    (unpred)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
endmodule

// File: tb/test_fp_sub_decode.sv
module test_fp_sub_decode;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] instr = '0;
  logic mixedSet = 1'b0, halfOk = 1'b0, inCondBlock = 1'b0;
  logic [2:0] vecLen = '0;
  logic [1:0] vecStride = '0;
  logic outValid, noMatch, isVector, undef, unpred;
  logic [1:0] elemSize, regCount;
  logic [2:0] laneCount;
  logic [4:0] dstReg, srcNReg, srcMReg;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fp_sub_decode i_fp_sub_decode (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .mixedSet(mixedSet), .halfOk(halfOk), .vecLen(vecLen),
    .vecStride(vecStride), .inCondBlock(inCondBlock),
    .outValid(outValid), .noMatch(noMatch), .isVector(isVector),
    .elemSize(elemSize), .laneCount(laneCount), .regCount(regCount),
    .dstReg(dstReg), .srcNReg(srcNReg), .srcMReg(srcMReg),
    .undef(undef), .unpred(unpred)
  );

  function automatic logic [31:0] encVec(input logic mx, input logic d, input logic sz,
      input logic [3:0] vn, input logic [3:0] vd, input logic n, input logic q,
      input logic m, input logic [3:0] vm);
    logic [8:0] top = mx ? 9'b111011110 : 9'b111100100;
    return {top, d, 1'b1, sz, vn, vd, 4'b1101, n, q, m, 1'b0, vm};
  endfunction

  function automatic logic [31:0] encSca(input logic mx, input logic [3:0] cond,
      input logic d, input logic [3:0] vn, input logic [3:0] vd, input logic [1:0] size,
      input logic n, input logic m, input logic [3:0] vm);
    logic [3:0] top = mx ? 4'b1110 : cond;
    return {top, 5'b11100, d, 2'b11, vn, vd, 2'b10, size, n, 1'b1, m, 1'b0, vm};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic mx, hok;
    logic [2:0] len;
    logic [1:0] str;
    logic blk;
    logic nm, vec;
    logic [1:0] es;
    logic [2:0] lanes;
    logic [1:0] regs;
    logic [4:0] d, n, m;
    logic ud, up;
  } row_t;

  localparam int ROWS = 19;
  localparam row_t TABLE [ROWS] = '{
    '{encVec(0,0,0,3,5,1,0,0,7), 0,1,0,0,0, 0,1,1,2,1, 5,19,7, 0,0},
    '{encVec(0,1,0,2,4,0,1,1,6), 0,1,0,0,0, 0,1,1,2,2, 20,2,22, 0,0},
    '{encVec(0,0,0,3,4,0,1,0,6), 0,1,0,0,0, 0,1,1,2,2, 4,3,6, 1,0},
    '{encVec(1,0,1,1,2,0,0,1,8), 1,1,0,0,0, 0,1,0,4,1, 2,1,24, 0,0},
    '{encVec(1,0,1,1,2,0,0,1,8), 1,1,0,0,1, 0,1,0,4,1, 2,1,24, 0,1},
    '{encVec(0,0,1,1,2,0,0,1,8), 0,0,0,0,0, 0,1,0,4,1, 2,1,24, 1,0},
    '{encSca(0,0,1,5,6,2,0,1,9), 0,1,0,0,0, 0,0,1,1,1, 13,10,19, 0,0},
    '{encSca(0,14,1,5,6,3,0,1,9), 0,1,0,0,0, 0,0,2,1,1, 22,5,25, 0,0},
    '{encSca(0,1,0,2,3,1,1,0,4), 0,1,0,0,0, 0,0,0,1,1, 6,5,8, 0,1},
    '{encSca(0,14,0,2,3,1,1,0,4), 0,1,0,0,0, 0,0,0,1,1, 6,5,8, 0,0},
    '{encSca(1,0,0,2,3,1,1,0,4), 1,1,0,0,1, 0,0,0,1,1, 6,5,8, 0,1},
    '{encSca(1,0,1,5,6,2,0,1,9), 1,1,1,0,0, 0,0,1,1,1, 13,10,19, 1,0},
    '{encSca(0,14,0,2,3,0,1,0,4), 0,1,0,0,0, 0,0,3,1,1, 6,5,8, 1,0},
    '{encSca(0,15,1,5,6,2,0,1,9), 0,1,0,0,0, 1,0,0,0,0, 0,0,0, 0,0},
    '{32'h0, 0,1,0,0,0, 1,0,0,0,0, 0,0,0, 0,0},
    '{encSca(0,1,0,2,3,1,1,0,4), 0,0,0,0,0, 0,0,0,1,1, 6,5,8, 1,0},
    '{encVec(0,0,0,3,5,1,0,0,7), 1,1,0,0,0, 1,0,0,0,0, 0,0,0, 0,0},
    '{encSca(0,14,1,5,6,2,0,1,9), 0,1,0,1,0, 0,0,1,1,1, 13,10,19, 1,0},
    '{encVec(1,0,1,2,3,0,1,0,4), 1,1,0,0,1, 0,1,0,4,2, 3,2,4, 1,0}
  };

  task automatic check(input string tag, input int row, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s row %0d: got %0h expected %0h", tag, row, got, exp);
    end
  endtask

  task automatic drive(input row_t r);
    @(negedge clk);
    instr = r.ins; mixedSet = r.mx; halfOk = r.hok; vecLen = r.len;
    vecStride = r.str; inCondBlock = r.blk; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset outValid", -1, outValid, 0);
    check("R10 reset dstReg", -1, dstReg, 0);
    check("R10 reset undef", -1, undef, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 idle outValid", -1, outValid, 0);

    for (int i = 0; i < ROWS; i++) begin
      drive(TABLE[i]);
      check("R10 outValid", i, outValid, 1);
      check("R1 noMatch", i, noMatch, TABLE[i].nm);
      check("R1 isVector", i, isVector, TABLE[i].vec);
      check("R2/R6 elemSize", i, elemSize, TABLE[i].es);
      check("R2/R6 laneCount", i, laneCount, TABLE[i].lanes);
      check("R2/R6 regCount", i, regCount, TABLE[i].regs);
      check("R5 dstReg", i, dstReg, TABLE[i].d);
      check("R5 srcNReg", i, srcNReg, TABLE[i].n);
      check("R5 srcMReg", i, srcMReg, TABLE[i].m);
      check("R3/R4/R7 undef", i, undef, TABLE[i].ud);
      check("R8/R9 unpred", i, unpred, TABLE[i].up);
    end

    // R10 hold: new word without inValid leaves outputs unchanged
    drive(TABLE[0]);
    @(negedge clk);
    instr = TABLE[1].ins;
    @(negedge clk);
    check("R10 hold outValid", -2, outValid, 0);
    check("R10 hold dstReg", -2, dstReg, 5);
    check("R10 hold srcNReg", -2, srcNReg, 19);
    check("R10 hold isVector", -2, isVector, 1);

    // R10 reset clears captured state
    rstN = 1'b0;
    @(negedge clk);
    check("R10 reset clears dstReg", -3, dstReg, 0);
    check("R10 reset clears isVector", -3, isVector, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule